// File: doc/BRIEF.md
# Secondary Bus Reset Controller

This block owns the software-held reset of the secondary side of a bus bridge. Software writes a hold bit in a small control register; while that bit is 1 the secondary reset pin is driven active, every bridge transaction and data queue is held in reset together with the secondary interface logic, and the primary interface answers with retry everything except Type 0 configuration accesses. The bit is only ever cleared by software. The register itself survives the reset, so configuration is kept.

The same bit tells the secondary-side units that can start bus work (a DMA channel and an address translation unit) to halt. Each unit finishes what it already has in flight on its local bus and then raises an idle acknowledge. The block records the acknowledge and reports that unit as quiescent until the hold is released. The translation unit also gets a clear strobe for its own configuration state. An optional one-cycle interrupt request marks the start of a hold.

All pins are plain control or status levels. The primary decode has no back-pressure: `pri_retry` is a combinational answer to the class on `pri_cls` in the same cycle that `pri_valid` is high.

Top module: `sec_bus_reset`

## Requirements
- R1: A write with bit 0 (hold) equal to 1 drives `sec_rst_n` low from the cycle after the write. It stays low until software writes bit 0 as 0, and no hardware event clears the bit.
- R2: While the hold bit is 1, all `NUM_Q` bits of `q_flush` and `sec_if_rst` are 1.
- R3: `cfg_rdata` always returns the last written value of bits 0 (hold) and 1 (interrupt enable). Asserting or releasing the secondary reset never changes it.
- R4: While held, `pri_retry` is 1 in any cycle with `pri_valid` high and `pri_cls` other than 2'b10 (Type 0 configuration). Class 2'b10 is never retried. The other class codes are 2'b00 memory, 2'b01 I/O and 2'b11 Type 1 configuration. When not held, `pri_retry` is 0.
- R5: `unit_halt` (bit 0 DMA, bit 1 address translation) goes high in the cycle after the write that sets the hold bit, and stays high while the bit is held.
- R6: `unit_quiet[i]` goes high in the cycle after a cycle in which `unit_halt[i]` and `idle_ack[i]` are both high. It stays high until the hold is released. An acknowledge given while not held has no effect.
- R7: `xlat_cfg_clr` is high exactly while the hold bit is 1.
- R8: `irq` pulses for one cycle, in the first cycle of a hold, when bit 1 of the register is 1 after the setting write. It stays low when bit 1 is 0.
- R9: In the cycle after a write that clears bit 0, `sec_rst_n`, `q_flush`, `sec_if_rst`, `unit_halt`, `unit_quiet`, `xlat_cfg_clr` and `pri_retry` are all released together.
- R10: After reset the register reads 0, `sec_rst_n` is 1, and every halt, flush, quiet, retry and irq output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 2 | Write data: bit 0 hold, bit 1 interrupt enable |
| cfg_rdata | output | 2 | Control register read value |
| sec_rst_n | output | 1 | Secondary bus reset pin, active low |
| q_flush | output | NUM_Q | Reset for each transaction/data queue |
| sec_if_rst | output | 1 | Reset for the secondary interface logic |
| pri_valid | input | 1 | Primary transaction present this cycle |
| pri_cls | input | 2 | Decoded primary transaction class |
| pri_retry | output | 1 | Answer the primary transaction with retry |
| unit_halt | output | N_UNITS | Stop-new-work request to each unit |
| idle_ack | input | N_UNITS | Unit reports its in-flight work finished |
| unit_quiet | output | N_UNITS | Unit known quiescent under the hold |
| xlat_cfg_clr | output | 1 | Clear for the translation unit's configuration |
| irq | output | 1 | One-cycle interrupt request at hold start |

## Verification
The hold bit is set with and without the interrupt enable, so that a missing or a spurious pulse can be told apart. Held for a long stretch, it shows that nothing clears it and that the register reads back unchanged. During the hold, all four transaction classes are presented, plus an idle primary bus, which separates the single exempt class from the retried ones. Idle acknowledges are given to one unit at a time and also before the hold, which shows that the quiescent flags are kept per unit and only record acknowledges given while halted. A clearing write then checks that every output is released in the same cycle.

// File: rtl/srst_pkg.sv
package srst_pkg;
  localparam int CTRL_W    = 2;
  localparam int HOLD_BIT  = 0;
  localparam int IRQEN_BIT = 1;
  localparam int CLS_W     = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_MEM  = 2'b00,
    CLS_IO   = 2'b01,
    CLS_CFG0 = 2'b10,
    CLS_CFG1 = 2'b11
  } pri_cls_t;
endpackage

// File: rtl/srst_ctrl_reg.sv
module srst_ctrl_reg
  import srst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] rdata,
  output logic              hold,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              hold_d;

  // Only a software write changes the register; nothing else touches it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      hold_d <= 1'b0;
    end else begin
      if (wr) ctrl_q <= wdata;
      hold_d <= ctrl_q[HOLD_BIT];
    end
  end

  assign rdata = ctrl_q;
  assign hold  = ctrl_q[HOLD_BIT];
  // First held cycle: hold is new, its delayed copy is not yet set.
  assign irq   = ctrl_q[HOLD_BIT] & ~hold_d & ctrl_q[IRQEN_BIT];

  AST_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(rdata)); // R1
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8
endmodule

// File: rtl/srst_unit_halt.sv
module srst_unit_halt (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic idle_ack,
  output logic halt,
  output logic quiet
);
  logic quiet_q;

  // Record an acknowledge only while the unit is being told to halt.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    quiet_q <= 1'b0;
    else if (hold) quiet_q <= quiet_q | idle_ack;
    else           quiet_q <= 1'b0;
  end

  assign halt  = hold;
  assign quiet = quiet_q & hold;

  AST_QUIET_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> halt); // R6
  AST_ACK_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && idle_ack && hold) ##1 hold |-> quiet); // R6
endmodule

// File: rtl/srst_pri_gate.sv
module srst_pri_gate
  import srst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             pri_valid,
  input  logic [CLS_W-1:0] pri_cls,
  output logic             pri_retry
);
  logic exempt;

  assign exempt    = (pri_cls == CLS_CFG0);
  assign pri_retry = pri_valid & hold & ~exempt;

  AST_CFG0_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_valid && pri_cls == CLS_CFG0) |-> !pri_retry); // R4
endmodule

// File: rtl/sec_bus_reset.sv
module sec_bus_reset
  import srst_pkg::*;
#(
  parameter int NUM_Q   = 4,
  parameter int N_UNITS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [CTRL_W-1:0]  cfg_wdata,
  output logic [CTRL_W-1:0]  cfg_rdata,
  output logic               sec_rst_n,
  output logic [NUM_Q-1:0]   q_flush,
  output logic               sec_if_rst,
  input  logic               pri_valid,
  input  logic [CLS_W-1:0]   pri_cls,
  output logic               pri_retry,
  output logic [N_UNITS-1:0] unit_halt,
  input  logic [N_UNITS-1:0] idle_ack,
  output logic [N_UNITS-1:0] unit_quiet,
  output logic               xlat_cfg_clr,
  output logic               irq
);
  localparam int XLAT_IDX = (N_UNITS > 1) ? 1 : 0;

  logic hold;

  srst_ctrl_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .hold  (hold),
    .irq   (irq)
  );

  srst_pri_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .pri_valid (pri_valid),
    .pri_cls   (pri_cls),
    .pri_retry (pri_retry)
  );

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    srst_unit_halt u_halt (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (hold),
      .idle_ack (idle_ack[g]),
      .halt     (unit_halt[g]),
      .quiet    (unit_quiet[g])
    );
  end

  assign sec_rst_n    = ~hold;
  assign q_flush      = {NUM_Q{hold}};
  assign sec_if_rst   = hold;
  assign xlat_cfg_clr = unit_halt[XLAT_IDX];

  AST_SET_DRIVES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[HOLD_BIT]) |=> !sec_rst_n); // R1
  AST_FLUSH_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_rst_n |-> (&q_flush && sec_if_rst && xlat_cfg_clr)); // R2
  AST_RETRY_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_rst_n && pri_valid && pri_cls != CLS_CFG0) |-> pri_retry); // R4
  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_wdata[HOLD_BIT]) |=>
      (sec_rst_n && q_flush == '0 && unit_halt == '0 && unit_quiet == '0 && !pri_retry)); // R9
endmodule

// File: tb/sec_bus_reset_test.sv
`timescale 1ns/1ps
module sec_bus_reset_test;
  localparam int NQ = 4;
  localparam int NU = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_wdata = '0;
  logic [1:0]    cfg_rdata;
  logic          sec_rst_n;
  logic [NQ-1:0] q_flush;
  logic          sec_if_rst;
  logic          pri_valid = 1'b0;
  logic [1:0]    pri_cls = 2'b00;
  logic          pri_retry;
  logic [NU-1:0] unit_halt;
  logic [NU-1:0] idle_ack = '0;
  logic [NU-1:0] unit_quiet;
  logic          xlat_cfg_clr;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  sec_bus_reset #(.NUM_Q(NQ), .N_UNITS(NU)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sec_rst_n(sec_rst_n), .q_flush(q_flush),
    .sec_if_rst(sec_if_rst), .pri_valid(pri_valid), .pri_cls(pri_cls),
    .pri_retry(pri_retry), .unit_halt(unit_halt), .idle_ack(idle_ack),
    .unit_quiet(unit_quiet), .xlat_cfg_clr(xlat_cfg_clr), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; on return the write edge has passed and
  // the first cycle after the write is being observed.
  task automatic reg_write(input logic [1:0] d);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic t_reset();
    pri_valid = 1'b1;
    pri_cls = 2'b00;
    #1;
    chk("R10 rdata", cfg_rdata, 0);
    chk("R10 sec_rst_n", sec_rst_n, 1);
    chk("R10 flush/halt/quiet", {q_flush, unit_halt, unit_quiet}, 0);
    chk("R10 irq", irq, 0);
    chk("R4 no retry when not held", pri_retry, 0);
    pri_valid = 1'b0;
  endtask

  task automatic t_early_ack();
    idle_ack = 2'b11;
    @(negedge clk);
    idle_ack = 2'b00;
  endtask

  task automatic t_set_irq();
    reg_write(2'b11);
    chk("R8 irq pulse", irq, 1);
    chk("R1 pin low", sec_rst_n, 0);
    chk("R2 flush", {q_flush, sec_if_rst}, 5'h1F);
    chk("R5 halts", unit_halt, 2'b11);
    chk("R7 xlat clear", xlat_cfg_clr, 1);
    chk("R6 early ack ignored", unit_quiet, 2'b00);
    @(negedge clk);
    chk("R8 irq single cycle", irq, 0);
  endtask

  task automatic t_retry();
    for (int c = 0; c < 4; c++) begin
      pri_valid = 1'b1;
      pri_cls = c[1:0];
      #1;
      chk("R4 retry by class", pri_retry, (c == 2) ? 0 : 1);
    end
    pri_valid = 1'b0;
    #1;
    chk("R4 no retry without valid", pri_retry, 0);
  endtask

  task automatic t_long_hold();
    repeat (20) @(negedge clk);
    chk("R1 still held", sec_rst_n, 0);
    chk("R3 register kept", cfg_rdata, 2'b11);
  endtask

  task automatic t_quiet();
    idle_ack = 2'b01;
    @(negedge clk);
    idle_ack = 2'b00;
    chk("R6 dma quiet only", unit_quiet, 2'b01);
    idle_ack = 2'b10;
    @(negedge clk);
    idle_ack = 2'b00;
    chk("R6 both quiet", unit_quiet, 2'b11);
    repeat (3) @(negedge clk);
    chk("R6 quiet sticky", unit_quiet, 2'b11);
  endtask

  task automatic t_clear();
    pri_valid = 1'b1;
    pri_cls = 2'b00;
    reg_write(2'b10);
    chk("R9 pin released", sec_rst_n, 1);
    chk("R9 flush released", {q_flush, sec_if_rst, xlat_cfg_clr}, 0);
    chk("R9 halts/quiet released", {unit_halt, unit_quiet}, 0);
    chk("R9 retry released", pri_retry, 0);
    chk("R3 readback after clear", cfg_rdata, 2'b10);
    pri_valid = 1'b0;
  endtask

  task automatic t_no_irq();
    reg_write(2'b00);
    reg_write(2'b01);
    chk("R8 no irq when disabled", irq, 0);
    chk("R1 pin low again", sec_rst_n, 0);
    chk("R3 readback", cfg_rdata, 2'b01);
    @(negedge clk);
    chk("R8 still no irq", irq, 0);
    reg_write(2'b00);
    chk("R9 released", sec_rst_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_early_ack();
    t_set_irq();
    t_retry();
    t_long_hold();
    t_quiet();
    t_clear();
    t_no_irq();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule